// File: doc/BRIEF.md
# Microwire EEPROM Device Responder

This block models the slave side of a small three-wire serial EEPROM. It sits on a system clock, samples a chip-select line, a serial clock and a serial data input, and answers on a single serial data output. It holds an internal word array, a write-enable latch and a programming-time counter. A serial master under development can talk to it in place of a real memory and check what it reads back.

A command opens at the first 1 sampled on a rising serial-clock edge while chip select is high. Two opcode bits and an address follow, and then a data field for the commands that carry one. The commands are: read one word, write one word, erase one word, write one value to every word, erase every word, and set or clear the write-enable latch. Reads shift out a 0 and then the stored word. Commands that change the array run when chip select drops. The output then reports busy (low) for a parameterised number of system clocks, and ready (high) afterwards.

The organisation is chosen by a parameter: 64 words of 16 bits with a 6-bit address (the default), or 128 bytes with a 7-bit address.

Top module: `mw_eeprom_resp`

## Requirements
- R1: After reset the output is high (ready), the write-enable latch is clear and every cell of the array reads as all ones.
- R2: Zeros clocked in before the first 1 with chip select high are ignored, and that first 1 is taken as the start bit.
- R3: After the start bit come two opcode bits and then the address, all MSB first. In word organisation the address is 6 bits. Opcode 10 is read, 01 is write, 11 is erase. For opcode 00 the two top address bits select the command: 00 clears the write-enable latch, 01 is write-all, 10 is erase-all and 11 sets the write-enable latch.
- R4: On a read, the output goes to 0 (dummy bit) in the clock after the rising serial-clock edge that carries the last address bit. Each following rising edge then presents the next data bit, MSB first. Once the data bits are exhausted, further edges present 0.
- R5: A write takes the 16 data bits that follow the address, MSB first, and stores them at that address when chip select drops.
- R6: Erase sets the addressed cell to all ones. Erase-all sets every cell to all ones. Write-all stores its 16-bit data field in every cell.
- R7: While the write-enable latch is clear, write, erase, write-all and erase-all change no cell and start no busy period.
- R8: When a modifying command is accepted as chip select drops, the output is low for exactly PROG_CYCLES system clocks, starting with the clock after the drop is sampled. After that it is high again.
- R9: If chip select drops before a command's last bit has arrived, the command is dropped and no cell changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the master; rising edges shift bits |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data / ready-busy output |

## Verification
Reads are tried with and without leading zeros in front of the start bit, to show that the start detector skips zeros and does not shift them into the opcode. Writes are issued once with the enable latch clear and once with it set, and the results are read back. A clear latch must leave the old contents and give no busy pulse, while a set latch must change the cell and give a busy pulse of exact length. Single-cell erase, write-all and erase-all are followed by reads at several addresses, which separates a single-cell update from a whole-array update. A write cut short after part of its data field shows that an incomplete command leaves the array untouched. A behavioural model of the protocol is also compared with the output on every clock.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    CMD_READ, CMD_WRITE, CMD_ERASE, CMD_LOCK, CMD_FILL, CMD_WIPE, CMD_UNLOCK
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DATA, ST_RD, ST_DONE
  } state_e;

  typedef struct packed {
    logic shiftHdr;   // shift one header bit
    logic shiftData;  // shift one data bit
    logic loadRd;     // fetch addressed word into output shifter
    logic shiftRd;    // advance output shifter
    logic wrOne;      // update addressed cell
    logic wrAll;      // update every cell
    logic fillOnes;   // update value is all ones instead of data field
  } strobe_t;

endpackage

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csel,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [ADDR_W+1:0] hdrFull,
  output strobe_t           strb,
  output logic              busy,
  output logic              rdActive
);
  localparam int HDR_W  = ADDR_W + 2;
  localparam int MAX_W  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W  = $clog2(MAX_W + 1);
  localparam int BUSY_W = $clog2(PROG_CYCLES + 1);

  logic              sclkQ, cselQ, welQ;
  state_e            state;
  cmd_e              cmdQ, decCmd;
  logic [CNT_W-1:0]  bitCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic              rise, fall, lastHdr, lastData, modifying, execute;

  assign busy     = (busyCnt != '0);
  assign rise     = csel && sclk && !sclkQ && !busy;
  assign fall     = cselQ && !csel && !busy;
  assign lastHdr  = (bitCnt == CNT_W'(HDR_W - 1));
  assign lastData = (bitCnt == CNT_W'(DATA_W - 1));
  assign rdActive = (state == ST_RD);

  always_comb begin
    unique case (hdrFull[HDR_W-1 -: 2])
      2'b10:   decCmd = CMD_READ;
      2'b01:   decCmd = CMD_WRITE;
      2'b11:   decCmd = CMD_ERASE;
      default: begin
        unique case (hdrFull[ADDR_W-1 -: 2])
          2'b00:   decCmd = CMD_LOCK;
          2'b01:   decCmd = CMD_FILL;
          2'b10:   decCmd = CMD_WIPE;
          default: decCmd = CMD_UNLOCK;
        endcase
      end
    endcase
  end

  assign modifying = (cmdQ == CMD_WRITE) || (cmdQ == CMD_ERASE) ||
                     (cmdQ == CMD_FILL)  || (cmdQ == CMD_WIPE);
  assign execute   = fall && (state == ST_DONE) && welQ && modifying;

  always_comb begin
    strb.shiftHdr  = rise && (state == ST_HDR);
    strb.shiftData = rise && (state == ST_DATA);
    strb.loadRd    = strb.shiftHdr && lastHdr && (decCmd == CMD_READ);
    strb.shiftRd   = rise && (state == ST_RD);
    strb.wrOne     = execute && ((cmdQ == CMD_WRITE) || (cmdQ == CMD_ERASE));
    strb.wrAll     = execute && ((cmdQ == CMD_FILL) || (cmdQ == CMD_WIPE));
    strb.fillOnes  = (cmdQ == CMD_ERASE) || (cmdQ == CMD_WIPE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      cselQ   <= 1'b0;
      welQ    <= 1'b0;
      state   <= ST_IDLE;
      cmdQ    <= CMD_READ;
      bitCnt  <= '0;
      busyCnt <= '0;
    end else begin
      sclkQ <= sclk;
      cselQ <= csel;
      if (busy) begin
        busyCnt <= busyCnt - BUSY_W'(1);
      end else if (!csel) begin
        state <= ST_IDLE;
        if (fall && state == ST_DONE) begin
          if (cmdQ == CMD_UNLOCK)    welQ <= 1'b1;
          else if (cmdQ == CMD_LOCK) welQ <= 1'b0;
          else if (execute)          busyCnt <= BUSY_W'(PROG_CYCLES);
        end
      end else if (rise) begin
        unique case (state)
          ST_IDLE: if (sdi) begin
            state  <= ST_HDR;
            bitCnt <= '0;
          end
          ST_HDR: begin
            bitCnt <= bitCnt + 1'b1;
            if (lastHdr) begin
              bitCnt <= '0;
              cmdQ   <= decCmd;
              if (decCmd == CMD_READ)                             state <= ST_RD;
              else if (decCmd == CMD_WRITE || decCmd == CMD_FILL) state <= ST_DATA;
              else                                                state <= ST_DONE;
            end
          end
          ST_DATA: begin
            bitCnt <= bitCnt + 1'b1;
            if (lastData) state <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  // R8: busy period counts down by one each clock
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busyCnt == ($past(busyCnt) - BUSY_W'(1))));

  // R7: a busy period only begins while the enable latch was set
  p_wel_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(welQ));

  // R3: header counter never passes the header length
  p_hdr_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HDR) |-> (bitCnt < CNT_W'(HDR_W)));

endmodule

// File: rtl/mw_datapath.sv
module mw_datapath
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  strobe_t           strb,
  input  logic              busy,
  input  logic              rdActive,
  output logic [ADDR_W+1:0] hdrFull,
  output logic              sdo
);
  localparam int HDR_W = ADDR_W + 2;
  localparam int DEPTH = 1 << ADDR_W;

  logic [HDR_W-1:0]  hdrQ;
  logic [DATA_W-1:0] dataQ, rdQ, wrVal;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              outQ;

  assign hdrFull = {hdrQ[HDR_W-2:0], sdi};
  assign wrVal   = strb.fillOnes ? '1 : dataQ;
  assign sdo     = busy ? 1'b0 : (rdActive ? outQ : 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrQ  <= '0;
      dataQ <= '0;
      rdQ   <= '0;
      outQ  <= 1'b0;
    end else begin
      if (strb.shiftHdr)  hdrQ  <= hdrFull;
      if (strb.shiftData) dataQ <= {dataQ[DATA_W-2:0], sdi};
      if (strb.loadRd) begin
        rdQ  <= mem[hdrFull[ADDR_W-1:0]];
        outQ <= 1'b0;
      end else if (strb.shiftRd) begin
        rdQ  <= {rdQ[DATA_W-2:0], 1'b0};
        outQ <= rdQ[DATA_W-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.wrAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= wrVal;
    end else if (strb.wrOne) begin
      mem[hdrQ[ADDR_W-1:0]] <= wrVal;
    end
  end

  // R4: the clock after a read is decoded shows the dummy 0
  p_dummy_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRd |=> !sdo);

endmodule

// File: rtl/mw_eeprom_resp.sv
module mw_eeprom_resp
  import mw_pkg::*;
#(
  parameter bit WORD_ORG    = 1'b1,
  parameter int PROG_CYCLES = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic csel,
  input  logic sclk,
  input  logic sdi,
  output logic sdo
);
  localparam int ADDR_W = WORD_ORG ? 6 : 7;
  localparam int DATA_W = WORD_ORG ? 16 : 8;

  strobe_t           strb;
  logic              busy, rdActive;
  logic [ADDR_W+1:0] hdrFull;

  mw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .csel(csel), .sclk(sclk), .sdi(sdi),
    .hdrFull(hdrFull), .strb(strb), .busy(busy), .rdActive(rdActive)
  );

  mw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .sdi(sdi), .strb(strb), .busy(busy),
    .rdActive(rdActive), .hdrFull(hdrFull), .sdo(sdo)
  );

  // R8: output reports busy for the whole programming period
  p_low_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdo);

endmodule

// File: tb/test_mw_eeprom_resp.sv
module test_mw_eeprom_resp;
  localparam int PROG = 20;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int HW = AW + 2;

  logic clk = 1'b0, rstN = 1'b0, csel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mw_eeprom_resp #(.WORD_ORG(1'b1), .PROG_CYCLES(PROG)) i_mw_eeprom_resp (
    .clk(clk), .rstN(rstN), .csel(csel), .sclk(sclk), .sdi(sdi), .sdo(sdo)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mMem [64];
  bit mBits [$];
  bit mSclk, mCs, started, reading, mWel, mOut;
  int need, mBusy, rdIdx, rdWord;
  logic mSdo = 1'b1;

  function automatic int fieldOf(int from, int n);
    int v = 0;
    for (int i = 0; i < n; i++) v = (v << 1) | int'(mBits[from + i]);
    return v;
  endfunction

  function automatic void runCmd();
    int op = fieldOf(0, 2);
    int a  = fieldOf(2, AW);
    int sub = fieldOf(2, 2);
    if (op == 1 && mWel) begin mMem[a] = fieldOf(HW, DW); mBusy = PROG; end
    else if (op == 3 && mWel) begin mMem[a] = 'hFFFF; mBusy = PROG; end
    else if (op == 0) begin
      if (sub == 0) mWel = 1'b0;
      else if (sub == 3) mWel = 1'b1;
      else if (mWel) begin
        for (int i = 0; i < 64; i++) mMem[i] = (sub == 1) ? fieldOf(HW, DW) : 'hFFFF;
        mBusy = PROG;
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mMem[i] = 'hFFFF;
      mBits.delete();
      mSclk = 0; mCs = 0; started = 0; reading = 0; mWel = 0; mOut = 0;
      need = HW; mBusy = 0; rdIdx = 0; rdWord = 0;
    end else begin
      if (mBusy > 0) mBusy--;
      else if (!csel) begin
        if (mCs && started && !reading && mBits.size() == need) runCmd();
        started = 0; reading = 0; mBits.delete(); need = HW;
      end else if (sclk && !mSclk) begin
        if (!started) started = sdi;
        else if (reading) begin
          mOut = (rdIdx >= 0) ? rdWord[rdIdx] : 1'b0;
          rdIdx--;
        end else if (mBits.size() < need) begin
          mBits.push_back(sdi);
          if (mBits.size() == HW) begin
            if (fieldOf(0, 2) == 2) begin
              reading = 1; mOut = 0; rdWord = mMem[fieldOf(2, AW)]; rdIdx = DW - 1;
            end else if (fieldOf(0, 2) == 1 || fieldOf(0, 4) == 1) need = HW + DW;
          end
        end
      end
      mSclk = sclk; mCs = csel;
      mSdo = (mBusy > 0) ? 1'b0 : (reading ? mOut : 1'b1);
    end
  end

  always @(negedge clk) if (rstN && !done)
    chk(sdo === mSdo, "R3 model", int'(sdo), int'(mSdo));

  // ---------------- master-side tasks ----------------
  task automatic pulse(input bit b, output bit s);
    @(negedge clk); sdi = b; sclk = 1'b0;
    repeat (2) @(negedge clk);
    s = sdo; sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sendBits(input int v, input int n);
    bit s;
    for (int i = n - 1; i >= 0; i--) pulse(((v >> i) & 1) != 0, s);
  endtask

  task automatic csOn();
    @(negedge clk); csel = 1'b1; sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic csOff(output int busyLen);
    @(negedge clk); csel = 1'b0; sclk = 1'b0;
    busyLen = 0;
    for (int i = 0; i < 4 * PROG; i++) begin
      @(negedge clk);
      if (sdo === 1'b0) busyLen++; else break;
    end
  endtask

  task automatic doRead(input int a, input int lead, output int dummy, output int word);
    bit s; int bl;
    csOn();
    if (lead > 0) sendBits(0, lead);
    sendBits(1, 1); sendBits(2, 2); sendBits(a, AW);
    pulse(1'b0, s); dummy = int'(s);
    word = 0;
    for (int i = 0; i < DW; i++) begin pulse(1'b0, s); word = (word << 1) | int'(s); end
    csOff(bl);
  endtask

  task automatic doSpecial(input int sub, input int data, output int bl);
    csOn();
    sendBits(1, 1); sendBits(0, 2); sendBits(sub, 2); sendBits(0, AW - 2);
    if (sub == 1) sendBits(data, DW);
    csOff(bl);
  endtask

  task automatic doWrite(input int a, input int d, input int nData, output int bl);
    csOn();
    sendBits(1, 1); sendBits(1, 2); sendBits(a, AW);
    sendBits(d >> (DW - nData), nData);
    csOff(bl);
  endtask

  task automatic doErase(input int a, output int bl);
    csOn();
    sendBits(1, 1); sendBits(3, 2); sendBits(a, AW);
    csOff(bl);
  endtask

  initial begin
    int dmy, w, bl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(sdo === 1'b1, "R1 ready after reset", int'(sdo), 1);
    doRead(40, 0, dmy, w);
    chk(w == 'hFFFF, "R1 cell after reset", w, 'hFFFF);

    doWrite(3, 'h1234, DW, bl);
    chk(bl == 0, "R7 no busy while locked", bl, 0);
    doRead(3, 0, dmy, w);
    chk(w == 'hFFFF, "R7 cell kept while locked", w, 'hFFFF);

    doSpecial(3, 0, bl);
    doWrite(3, 'h1234, DW, bl);
    chk(bl == PROG, "R8 busy length", bl, PROG);
    doRead(3, 0, dmy, w);
    chk(dmy == 0, "R4 dummy bit", dmy, 0);
    chk(w == 'h1234, "R5 written word", w, 'h1234);
    doRead(3, 3, dmy, w);
    chk(w == 'h1234, "R2 leading zeros", w, 'h1234);

    doWrite(62, 'h8001, DW, bl);
    doErase(3, bl);
    chk(bl == PROG, "R8 erase busy length", bl, PROG);
    doRead(3, 0, dmy, w);
    chk(w == 'hFFFF, "R6 erase one", w, 'hFFFF);
    doRead(62, 0, dmy, w);
    chk(w == 'h8001, "R6 erase leaves neighbour", w, 'h8001);

    doSpecial(1, 'hBEEF, bl);
    chk(bl == PROG, "R8 write-all busy", bl, PROG);
    doRead(0, 0, dmy, w);
    chk(w == 'hBEEF, "R6 write-all low", w, 'hBEEF);
    doRead(63, 0, dmy, w);
    chk(w == 'hBEEF, "R6 write-all high", w, 'hBEEF);

    doSpecial(2, 0, bl);
    doRead(17, 0, dmy, w);
    chk(w == 'hFFFF, "R6 erase-all", w, 'hFFFF);

    doWrite(10, 'h5A5A, DW, bl);
    doWrite(10, 'h0000, 10, bl);
    chk(bl == 0, "R9 aborted no busy", bl, 0);
    doRead(10, 0, dmy, w);
    chk(w == 'h5A5A, "R9 aborted cell kept", w, 'h5A5A);

    doSpecial(0, 0, bl);
    doWrite(10, 'h1111, DW, bl);
    chk(bl == 0, "R7 relocked no busy", bl, 0);
    doRead(10, 0, dmy, w);
    chk(w == 'h5A5A, "R7 relocked cell kept", w, 'h5A5A);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule